// File: doc/BRIEF.md
# Video Timing Reference Code Decoder

This block monitors a 10-bit digital component video sample stream and recognises the four-word timing reference codes embedded in it. A code is a three-word preamble (one word of all ones, then two words of all zeros) followed by a status word. The status word carries three line flags: field, vertical blanking and horizontal blanking. It also carries four protection bits computed from those flags.

The decoder checks the flags against the protection bits. A status word with one bit in error is corrected. A status word with two bits in error is reported and otherwise discarded. For each good or corrected code, the block emits a one-cycle start-of-active-video or end-of-active-video strobe, chosen by the horizontal flag, and updates its held field, vertical and horizontal outputs.

The two least significant bits of every word are ignored. An 8-bit source placed in the upper bits of the bus therefore works unchanged. Downstream line and pixel logic uses the strobes and flags to frame active video.

Top module: `trc_decoder`

## Requirements
- R1: While reset is active and after it is released, before any code is decoded, sav_o, eav_o, sec_o and derr_o are 0 and f_o, v_o and h_o are 0.
- R2: After accepted words whose bits 9..2 are FFh, 00h and 00h, the next accepted word is the status word. If that word has bit 9 = 1 and decodes without an uncorrectable error, exactly one of sav_o (corrected H = 0) or eav_o (corrected H = 1) is high for one cycle. The strobe appears in the cycle after the clock edge that accepts the status word.
- R3: In the status word, bit 8 is F, bit 7 is V, bit 6 is H and bits 5..2 are P3..P0. f_o, v_o and h_o take the corrected values with the strobe and hold them until the next good code.
- R4: The valid codewords satisfy P3 = V^H, P2 = F^H, P1 = F^V and P0 = F^V^H. A status word that is exactly a valid codeword gives sec_o = 0 and derr_o = 0.
- R5: A status word at Hamming distance 1 from a valid codeword, counted over the 7 bits F, V, H and P3..P0, is corrected to that codeword's flags, and sec_o pulses together with the strobe.
- R6: A status word at distance 2 or more from every codeword pulses derr_o for one cycle. sav_o and eav_o stay 0, and f_o, v_o and h_o keep their previous values.
- R7: Bits 1..0 of every word have no effect on preamble matching or status decoding.
- R8: A word with valid_i = 0 is ignored: it neither advances nor breaks the preamble match, and it produces no strobe.
- R9: An accepted word that breaks the preamble restarts the match. If the breaking word is FFh in bits 9..2, it counts as the first preamble word.
- R10: A word in the status position with bit 9 = 0 produces no strobe, no sec_o and no derr_o. The matcher then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on data_i is accepted this cycle |
| data_i | input | 10 | Video sample word |
| sav_o | output | 1 | Start-of-active-video strobe |
| eav_o | output | 1 | End-of-active-video strobe |
| f_o | output | 1 | Held corrected field flag |
| v_o | output | 1 | Held corrected vertical blanking flag |
| h_o | output | 1 | Held corrected horizontal flag |
| sec_o | output | 1 | Single-bit error corrected strobe |
| derr_o | output | 1 | Uncorrectable error strobe |

## Verification
A preamble matcher stuck in the wrong state shows up at the first code that follows. It either misses a strobe there, or it raises a strobe one accepted word too early or too late after the status position. A fault in the correction table shows up in the very cycle after the affected status word is accepted: the flags, sec_o or derr_o take the wrong value. A wrong held flag stays visible on f_o, v_o and h_o until the next good code. Random streams therefore mix preamble fragments, noisy status words and valid gaps, and the bench compares every output in every cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    SEEK_ONES,
    SEEK_Z1,
    SEEK_Z2,
    SEEK_STAT
  } trc_state_e;

  // fvh = {f, v, h}; returns {p3, p2, p1, p0}
  function automatic logic [3:0] trc_prot(input logic [2:0] fvh);
    return {fvh[1] ^ fvh[0], fvh[2] ^ fvh[0], fvh[2] ^ fvh[1], ^fvh};
  endfunction

endpackage

// File: rtl/trc_preamble_fsm.sv
module trc_preamble_fsm #(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             stat_hit_o
);
  import trc_pkg::*;

  trc_state_e state_q, state_d;
  logic is_ones, is_zero;

  assign is_ones = &key_i;
  assign is_zero = ~|key_i;

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      unique case (state_q)
        SEEK_ONES: state_d = is_ones ? SEEK_Z1 : SEEK_ONES;
        SEEK_Z1:   state_d = is_zero ? SEEK_Z2 : (is_ones ? SEEK_Z1 : SEEK_ONES);
        SEEK_Z2:   state_d = is_zero ? SEEK_STAT : (is_ones ? SEEK_Z1 : SEEK_ONES);
        SEEK_STAT: state_d = SEEK_ONES;
        default:   state_d = SEEK_ONES;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEEK_ONES;
    else         state_q <= state_d;
  end

  // status word consumed; marker bit must be set
  assign stat_hit_o = valid_i && (state_q == SEEK_STAT) && key_i[KEY_W-1];

  assert_gap_holds_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));

  assert_stat_from_z2_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEEK_STAT) |-> $past(state_q) == SEEK_Z2 || $past(state_q) == SEEK_STAT);

endmodule

// File: rtl/trc_status_ecc.sv
module trc_status_ecc (
  input  logic [6:0] rx_i,   // {f, v, h, p3, p2, p1, p0}
  output logic [2:0] fvh_o,
  output logic [7:0] hit_o,
  output logic       corr_o,
  output logic       uncorr_o
);
  import trc_pkg::*;

  logic [7:0] exact;
  logic [7:0] near;

  for (genvar g = 0; g < 8; g++) begin : g_cw
    localparam logic [2:0] FVH = 3'(g);
    localparam logic [6:0] CW  = {FVH, trc_prot(FVH)};
    logic [6:0] diff;
    assign diff     = rx_i ^ CW;
    assign exact[g] = (diff == 7'd0);
    assign near[g]  = ($countones(diff) == 1);
  end

  assign hit_o    = exact | near;
  assign corr_o   = |near;
  assign uncorr_o = ~|hit_o;

  always_comb begin
    fvh_o = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if (hit_o[i]) fvh_o = fvh_o | 3'(i);
    end
  end

endmodule

// File: rtl/trc_decoder.sv
module trc_decoder #(
  parameter int DATA_W  = 10,
  parameter int IGN_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sav_o,
  output logic              eav_o,
  output logic              f_o,
  output logic              v_o,
  output logic              h_o,
  output logic              sec_o,
  output logic              derr_o
);
  localparam int KEY_W = DATA_W - IGN_LSB;

  logic [KEY_W-1:0] key;
  logic [6:0]       rx;
  logic             stat_hit;
  logic [2:0]       fvh;
  logic [7:0]       hit;
  logic             corr, uncorr;

  assign key = data_i[DATA_W-1:IGN_LSB];
  assign rx  = key[KEY_W-2 -: 7];

  trc_preamble_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .key_i      (key),
    .stat_hit_o (stat_hit)
  );

  trc_status_ecc u_ecc (
    .rx_i     (rx),
    .fvh_o    (fvh),
    .hit_o    (hit),
    .corr_o   (corr),
    .uncorr_o (uncorr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sav_o  <= 1'b0;
      eav_o  <= 1'b0;
      sec_o  <= 1'b0;
      derr_o <= 1'b0;
      f_o    <= 1'b0;
      v_o    <= 1'b0;
      h_o    <= 1'b0;
    end else begin
      sav_o  <= 1'b0;
      eav_o  <= 1'b0;
      sec_o  <= 1'b0;
      derr_o <= 1'b0;
      if (stat_hit) begin
        if (uncorr) begin
          derr_o <= 1'b1;
        end else begin
          {f_o, v_o, h_o} <= fvh;
          sav_o <= ~fvh[0];
          eav_o <= fvh[0];
          sec_o <= corr;
        end
      end
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sav_o && eav_o));

  assert_eav_has_h_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |-> h_o);

  assert_sav_no_h_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_o |-> !h_o);

  assert_single_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));

  assert_derr_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    derr_o |-> (!sav_o && !eav_o && !sec_o && $stable({f_o, v_o, h_o})));

  assert_needs_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sav_o || eav_o || derr_o) |-> $past(valid_i));

endmodule

// File: tb/trc_decoder_tb_top.sv
`timescale 1ns/1ps
module trc_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [9:0] din = 10'd0;
  logic sav, eav, f, v, h, sec, derr;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int   m_st = 0;
  logic e_sav = 0, e_eav = 0, e_f = 0, e_v = 0, e_h = 0, e_sec = 0, e_derr = 0;

  always #2.5 clk = ~clk;

  trc_decoder dut_i (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (vld), .data_i (din),
    .sav_o (sav), .eav_o (eav), .f_o (f), .v_o (v), .h_o (h),
    .sec_o (sec), .derr_o (derr)
  );

  function automatic logic [3:0] prot(input logic [2:0] fvh);
    return {fvh[1] ^ fvh[0], fvh[2] ^ fvh[0], fvh[2] ^ fvh[1], fvh[2] ^ fvh[1] ^ fvh[0]};
  endfunction

  function automatic logic [9:0] stat_w(input logic [2:0] fvh, input logic [6:0] flip);
    logic [6:0] b;
    b = {fvh, prot(fvh)} ^ flip;
    return {1'b1, b, 2'b00};
  endfunction

  // returns {derr, sec, f, v, h}
  function automatic logic [4:0] ref_dec(input logic [6:0] rx);
    for (int c = 0; c < 8; c++) begin
      logic [6:0] cw;
      cw = {3'(c), prot(3'(c))};
      if (rx == cw) return {2'b00, 3'(c)};
    end
    for (int c = 0; c < 8; c++) begin
      logic [6:0] cw;
      cw = {3'(c), prot(3'(c))};
      for (int b = 0; b < 7; b++)
        if (rx == (cw ^ 7'(1 << b))) return {2'b01, 3'(c)};
    end
    return 5'b10000;
  endfunction

  task automatic model(input logic [9:0] w, input logic vv);
    logic [7:0] k;
    logic [4:0] r;
    e_sav = 0; e_eav = 0; e_sec = 0; e_derr = 0;
    if (!vv) return;
    k = w[9:2];
    case (m_st)
      0: m_st = (k == 8'hFF) ? 1 : 0;
      1, 2: m_st = (k == 8'h00) ? m_st + 1 : ((k == 8'hFF) ? 1 : 0);
      default: begin
        m_st = 0;
        if (w[9]) begin
          r = ref_dec(w[8:2]);
          if (r[4]) e_derr = 1;
          else begin
            {e_f, e_v, e_h} = r[2:0];
            e_sec = r[3];
            e_sav = !r[0];
            e_eav = r[0];
          end
        end
      end
    endcase
  endtask

  task automatic check(input string tag);
    logic [6:0] got, exp;
    got = {sav, eav, f, v, h, sec, derr};
    exp = {e_sav, e_eav, e_f, e_v, e_h, e_sec, e_derr};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s sav,eav,f,v,h,sec,derr got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic step(input logic [9:0] w, input logic vv, input string tag);
    @(negedge clk);
    din = w;
    vld = vv;
    model(w, vv);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic preamble(input string tag);
    step(10'h3FF, 1, tag);
    step(10'h000, 1, tag);
    step(10'h000, 1, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #1 check("R1 after reset");

    // R2, R4: exact codes, SAV then EAV
    preamble("R2"); step(stat_w(3'b000, 7'd0), 1, "R2 R4 sav 000");
    step(10'h200, 1, "R2 idle");
    preamble("R2"); step(stat_w(3'b001, 7'd0), 1, "R2 R4 eav 001");
    // R3: field and vblank positions
    preamble("R3"); step(stat_w(3'b110, 7'd0), 1, "R3 fvh 110");
    step(10'h000, 1, "R3 hold");
    preamble("R3"); step(stat_w(3'b101, 7'd0), 1, "R3 fvh 101");
    // R5: every single-bit flip on a codeword
    for (int b = 0; b < 7; b++) begin
      preamble("R5"); step(stat_w(3'b011, 7'(1 << b)), 1, "R5 single flip");
    end
    // R5: P=0000 FVH=001 -> 000 ; P=0001 FVH=011 -> 111
    preamble("R5"); step({1'b1, 3'b001, 4'b0000, 2'b00}, 1, "R5 to 000");
    preamble("R5"); step({1'b1, 3'b011, 4'b0001, 2'b00}, 1, "R5 to 111");
    // R6: double errors hold flags
    preamble("R6"); step({1'b1, 3'b011, 4'b0000, 2'b00}, 1, "R6 derr a");
    preamble("R6"); step({1'b1, 3'b001, 4'b0001, 2'b00}, 1, "R6 derr b");
    step(10'h000, 1, "R6 flags held");
    // R7: noisy LSBs
    step(10'h3FC, 1, "R7"); step(10'h003, 1, "R7"); step(10'h001, 1, "R7");
    step(stat_w(3'b010, 7'd0) | 10'h3, 1, "R7 lsb noise");
    // R8: gaps inside the code
    step(10'h3FF, 1, "R8"); step(10'h155, 0, "R8 gap"); step(10'h000, 1, "R8");
    step(10'h3FF, 0, "R8 gap"); step(10'h000, 1, "R8");
    step(stat_w(3'b100, 7'd0), 0, "R8 gap");
    step(stat_w(3'b100, 7'd0), 1, "R8 status after gaps");
    // R9: repeated ones and broken sequences
    step(10'h3FF, 1, "R9"); preamble("R9"); step(stat_w(3'b001, 7'd0), 1, "R9 double ones");
    step(10'h3FF, 1, "R9"); step(10'h000, 1, "R9"); preamble("R9");
    step(stat_w(3'b000, 7'd0), 1, "R9 ones restart");
    step(10'h3FF, 1, "R9"); step(10'h000, 1, "R9"); step(10'h124, 1, "R9 break");
    step(10'h000, 1, "R9"); step(stat_w(3'b111, 7'd0), 1, "R9 no code after break");
    // R10: marker bit clear
    preamble("R10"); step({1'b0, 3'b001, prot(3'b001), 2'b00}, 1, "R10 marker clear");
    step(stat_w(3'b001, 7'd0), 1, "R10 restarted");

    // random mix covering R2 to R10
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] w;
      logic [6:0] fl;
      int sel;
      sel = $urandom % 8;
      fl = 7'd0;
      if (sel >= 4 && sel <= 5) begin
        int nf;
        nf = $urandom % 3;
        for (int j = 0; j < nf; j++) fl[$urandom % 7] = 1'b1;
      end
      case (sel)
        0, 1: w = {8'hFF, 2'($urandom)};
        2, 3: w = {8'h00, 2'($urandom)};
        4, 5: w = stat_w(3'($urandom), fl) | 10'($urandom % 4);
        6: w = 10'($urandom);
        default: w = {1'b0, 9'($urandom)};
      endcase
      step(w, ($urandom % 5) != 0, "R2 R5 R6 R8 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule